// File: doc/BRIEF.md
# Continuous-Program Command Sequencer for a Serial Flash Slave

This block decodes commands for a serial flash slave and tracks the continuous-program mode. In this mode a host writes a run of bytes to consecutive addresses without sending an address for each byte. The block samples the chip-select, serial clock and serial data input against a faster system clock. It collects whole command frames and acts on each one when chip-select rises. For each accepted byte it sends a one-cycle program request, carrying an address and a data byte, to an external program engine. The engine reports back through a busy flag.

The first program frame carries the opcode, a full address and one data byte, and it switches the block into continuous-program mode. Each later frame carries only the opcode and a data byte, and the block programs it at the previous address plus one. While the mode is active the block accepts only a short list of opcodes. The host leaves the mode with a write-disable frame, and only once the engine is idle.

Two status bytes can be read back on the serial output. As an option, the serial output can instead carry a live ready/busy level for the whole time chip-select is low.

Top module: `cpm_sequencer`

## Requirements
- R1: A frame is acted on only at the rising edge of chip-select, and only if it holds at least one byte and no partial byte. A frame that ends partway through a byte has no effect.
- R2: Outside the mode, a frame of exactly opcode 0xAD, ADDR_W/8 address bytes (most significant byte first) and one data byte, received while WIP=0, does three things: it issues one single-cycle program request with that address and data, it sets WIP, and it enters continuous-program mode.
- R3: Inside the mode, a two-byte frame (0xAD, data) received while WIP=0 issues a program request at the previous request address plus one. The address wraps from all-ones to zero.
- R4: A program frame received while WIP=1 is ignored: no request is issued, and the next accepted frame still uses the old address plus one. A request is never issued while the engine reports busy.
- R5: Inside the mode, only opcodes 0xAD, 0x04, 0x05 and 0x2B have any effect. Every other opcode, including 0x70 and 0x80, is ignored.
- R6: The single-byte opcode 0x04 ends the mode only when WIP=0. If WIP=1 the mode stays active.
- R7: Opcode 0x05 returns a status byte on the serial output. Bit 0 is WIP and the other bits are 0. The byte is sent most significant bit first, one bit per serial clock falling edge, and is sent again for as long as clocking continues. WIP is set when a request is issued and clears when the engine busy flag falls.
- R8: Opcode 0x2B returns a byte whose bit 4 is the continuous-program mode flag. All other bits are 0.
- R9: Outside the mode, the single-byte opcode 0x70 enables ready/busy output and 0x80 disables it. Inside the mode, neither opcode changes that setting.
- R10: While ready/busy output is enabled, the mode is active and chip-select is low, the serial output is driven for the whole time with the inverse of WIP: 0 means busy and 1 means ready.
- R11: The serial output enable is 0 whenever chip-select is high.
- R12: With ready/busy output disabled, status reads inside the mode return the normal status bytes of R7 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which must be several times faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip-select, active low |
| sclk | input | 1 | Serial clock. Input bits are taken on its rising edge and output bits change on its falling edge |
| si | input | 1 | Serial data input |
| so | output | 1 | Serial data output value |
| so_en | output | 1 | Serial output enable. When it is 0, the pad is high impedance |
| prog_req | output | 1 | Single-cycle program request to the engine |
| prog_addr | output | ADDR_W | Byte address of the current request |
| prog_data | output | 8 | Data byte of the current request |
| prog_busy | input | 1 | Engine busy flag |

## Verification
The bench builds the block with ADDR_W=24, two synchronizer stages and ready/busy support present. At 24 bits, the first program frame is five bytes long, which exercises the address collection over several bytes. The bench starts a run at 0xFFFFFE so the address wrap to zero is reached within three bytes. The engine model stays busy much longer than one status read takes, so reads while busy, frames sent while busy, and write-disable attempts all happen inside a single program cycle. Because ready/busy support is present, the bench can watch the serial output switch between a busy level, a ready level and normal status data.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
   localparam logic [7:0] OPC_CP     = 8'hAD;
   localparam logic [7:0] OPC_WRDI   = 8'h04;
   localparam logic [7:0] OPC_RDSR   = 8'h05;
   localparam logic [7:0] OPC_RDSCUR = 8'h2B;
   localparam logic [7:0] OPC_RB_ON  = 8'h70;
   localparam logic [7:0] OPC_RB_OFF = 8'h80;

   localparam int WIP_BIT = 0;
   localparam int CPM_BIT = 4;

   // opcodes that keep effect while continuous-program mode is active
   function automatic logic cp_whitelist(input logic [7:0] op);
      return (op == OPC_CP) || (op == OPC_WRDI) ||
             (op == OPC_RDSR) || (op == OPC_RDSCUR);
   endfunction
endpackage

// File: rtl/cpm_spi_rx.sv
module cpm_spi_rx #(
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             sclk,
   input  logic             si,
   output logic             sel,
   output logic             sck_fall,
   output logic             byte_stb,
   output logic [7:0]       byte_val,
   output logic [CNT_W-1:0] byte_idx,
   output logic             frame_end,
   output logic             frame_whole,
   output logic [CNT_W-1:0] frame_bytes
);
   localparam int LINES = 3;

   logic [LINES-1:0] stg [SYNC_STAGES];
   logic             cs_s, sck_s, si_s, cs_d, sck_d, sck_rise;
   logic [2:0]       bit_cnt;
   logic [6:0]       shreg;
   logic [CNT_W-1:0] byte_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= 3'b100;
      end else begin
         stg[0] <= {cs_n, sclk, si};
         for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign cs_s  = stg[SYNC_STAGES-1][2];
   assign sck_s = stg[SYNC_STAGES-1][1];
   assign si_s  = stg[SYNC_STAGES-1][0];

   assign sel      = !cs_s;
   assign sck_rise = !cs_s && sck_s && !sck_d;
   assign sck_fall = !cs_s && !sck_s && sck_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d     <= 1'b1;
         sck_d    <= 1'b0;
         bit_cnt  <= '0;
         byte_cnt <= '0;
         shreg    <= '0;
         byte_stb <= 1'b0;
         byte_val <= '0;
         byte_idx <= '0;
      end else begin
         cs_d     <= cs_s;
         sck_d    <= sck_s;
         byte_stb <= 1'b0;
         if (cs_s) begin
            bit_cnt  <= '0;
            byte_cnt <= '0;
         end else if (sck_rise) begin
            shreg   <= {shreg[5:0], si_s};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
               byte_stb <= 1'b1;
               byte_val <= {shreg, si_s};
               byte_idx <= byte_cnt;
               if (byte_cnt != '1) byte_cnt <= byte_cnt + 1'b1;
            end
         end
      end
   end

   assign frame_end   = cs_s && !cs_d;
   assign frame_whole = (bit_cnt == 3'd0) && (byte_cnt != '0);
   assign frame_bytes = byte_cnt;
endmodule

// File: rtl/cpm_ctrl.sv
module cpm_ctrl #(
   parameter int ADDR_W     = 24,
   parameter int CNT_W      = 3,
   parameter bit RB_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_stb,
   input  logic [7:0]        byte_val,
   input  logic [CNT_W-1:0]  byte_idx,
   input  logic              frame_end,
   input  logic              frame_whole,
   input  logic [CNT_W-1:0]  frame_bytes,
   input  logic              prog_busy,
   output logic              prog_req,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [7:0]        prog_data,
   output logic              wip,
   output logic              cp_mode,
   output logic              rb_on
);
   import cpm_pkg::*;

   localparam int AB        = ADDR_W / 8;
   localparam int LONG_LEN  = AB + 2;
   localparam int SHORT_LEN = 2;

   logic [7:0]        op_q, data_long, data_short;
   logic [ADDR_W-1:0] addr_acc, acc_next;
   logic              busy_d, go, accept;
   logic              start_long, step_short, exit_cp, rb_set, rb_clr;

   generate
      if (AB == 1) begin : g_addr_one
         assign acc_next = byte_val;
      end else begin : g_addr_multi
         assign acc_next = {addr_acc[ADDR_W-9:0], byte_val};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q       <= '0;
         addr_acc   <= '0;
         data_long  <= '0;
         data_short <= '0;
      end else if (byte_stb) begin
         if (byte_idx == '0) op_q <= byte_val;
         if (byte_idx >= CNT_W'(1) && byte_idx <= CNT_W'(AB)) addr_acc <= acc_next;
         if (byte_idx == CNT_W'(AB + 1)) data_long <= byte_val;
         if (byte_idx == CNT_W'(1)) data_short <= byte_val;
      end
   end

   always_comb begin
      go         = frame_end && frame_whole;
      accept     = go && (!cp_mode || cp_whitelist(op_q));
      start_long = accept && !cp_mode && !wip && op_q == OPC_CP &&
                   frame_bytes == CNT_W'(LONG_LEN);
      step_short = accept && cp_mode && !wip && op_q == OPC_CP &&
                   frame_bytes == CNT_W'(SHORT_LEN);
      exit_cp    = accept && cp_mode && !wip && op_q == OPC_WRDI &&
                   frame_bytes == CNT_W'(1);
      rb_set     = accept && !cp_mode && op_q == OPC_RB_ON  && frame_bytes == CNT_W'(1);
      rb_clr     = accept && !cp_mode && op_q == OPC_RB_OFF && frame_bytes == CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_req  <= 1'b0;
         prog_addr <= '0;
         prog_data <= '0;
         wip       <= 1'b0;
         cp_mode   <= 1'b0;
         busy_d    <= 1'b0;
      end else begin
         busy_d   <= prog_busy;
         prog_req <= start_long || step_short;
         if (start_long) begin
            prog_addr <= addr_acc;
            prog_data <= data_long;
            cp_mode   <= 1'b1;
         end
         if (step_short) begin
            prog_addr <= prog_addr + 1'b1;
            prog_data <= data_short;
         end
         if (exit_cp) cp_mode <= 1'b0;
         if (start_long || step_short) wip <= 1'b1;
         else if (busy_d && !prog_busy) wip <= 1'b0;
      end
   end

   generate
      if (RB_SUPPORT) begin : g_rb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rb_on <= 1'b0;
            else if (rb_set) rb_on <= 1'b1;
            else if (rb_clr) rb_on <= 1'b0;
         end
      end else begin : g_no_rb
         logic unused_rb;
         assign unused_rb = rb_set | rb_clr;
         assign rb_on = 1'b0;
      end
   endgenerate

   AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |=> !prog_req);                                   // R2
   AST_REQ_ENGINE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |-> !prog_busy);                                  // R4
   AST_CP_EXIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cp_mode) |-> !$past(wip));                           // R6
   AST_RB_FROZEN_IN_CP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cp_mode) |-> $stable(rb_on));                        // R9
endmodule

// File: rtl/cpm_so.sv
module cpm_so #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             sel,
   input  logic             sck_fall,
   input  logic             byte_stb,
   input  logic [7:0]       byte_val,
   input  logic [CNT_W-1:0] byte_idx,
   input  logic             wip,
   input  logic             cp_mode,
   input  logic             rb_on,
   output logic             so,
   output logic             so_en
);
   import cpm_pkg::*;

   logic [7:0] st_sr, st_sec, sh;
   logic [2:0] sh_cnt;
   logic       rd_pend, rd_act, rd_sec, rb_drive;

   always_comb begin
      st_sr          = '0;
      st_sr[WIP_BIT] = wip;
      st_sec          = '0;
      st_sec[CPM_BIT] = cp_mode;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_pend <= 1'b0;
         rd_act  <= 1'b0;
         rd_sec  <= 1'b0;
         sh      <= '0;
         sh_cnt  <= '0;
      end else if (!sel) begin
         rd_pend <= 1'b0;
         rd_act  <= 1'b0;
      end else begin
         if (byte_stb && byte_idx == '0 &&
             (byte_val == OPC_RDSR || byte_val == OPC_RDSCUR)) begin
            rd_pend <= 1'b1;
            rd_sec  <= (byte_val == OPC_RDSCUR);
         end
         if (sck_fall) begin
            if (rd_pend) begin
               rd_pend <= 1'b0;
               rd_act  <= 1'b1;
               sh      <= rd_sec ? st_sec : st_sr;
               sh_cnt  <= '0;
            end else if (rd_act) begin
               if (sh_cnt == 3'd7) sh <= rd_sec ? st_sec : st_sr;
               else                sh <= {sh[6:0], 1'b0};
               sh_cnt <= sh_cnt + 3'd1;
            end
         end
      end
   end

   assign rb_drive = rb_on && cp_mode;
   assign so       = rb_drive ? !wip : sh[7];
   assign so_en    = !cs_n && (rb_drive || rd_act);

   AST_SO_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !so_en);                                          // R11
endmodule

// File: rtl/cpm_sequencer.sv
module cpm_sequencer #(
   parameter int ADDR_W      = 24,
   parameter int SYNC_STAGES = 2,
   parameter bit RB_SUPPORT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              si,
   output logic              so,
   output logic              so_en,
   output logic              prog_req,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [7:0]        prog_data,
   input  logic              prog_busy
);
   localparam int LONG_LEN = ADDR_W / 8 + 2;
   localparam int CNT_W    = $clog2(LONG_LEN + 2);

   initial begin
      assert (ADDR_W >= 8 && ADDR_W % 8 == 0)
         else $error("ADDR_W must be a whole number of bytes");
      assert (SYNC_STAGES >= 2)
         else $error("SYNC_STAGES must be at least 2");
   end

   logic             sel, sck_fall, byte_stb, frame_end, frame_whole;
   logic [7:0]       byte_val;
   logic [CNT_W-1:0] byte_idx, frame_bytes;
   logic             wip, cp_mode, rb_on;

   cpm_spi_rx #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .si(si),
      .sel(sel), .sck_fall(sck_fall), .byte_stb(byte_stb),
      .byte_val(byte_val), .byte_idx(byte_idx), .frame_end(frame_end),
      .frame_whole(frame_whole), .frame_bytes(frame_bytes)
   );

   cpm_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .RB_SUPPORT(RB_SUPPORT)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .byte_val(byte_val),
      .byte_idx(byte_idx), .frame_end(frame_end), .frame_whole(frame_whole),
      .frame_bytes(frame_bytes), .prog_busy(prog_busy), .prog_req(prog_req),
      .prog_addr(prog_addr), .prog_data(prog_data), .wip(wip),
      .cp_mode(cp_mode), .rb_on(rb_on)
   );

   cpm_so #(.CNT_W(CNT_W)) u_so (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sel(sel), .sck_fall(sck_fall),
      .byte_stb(byte_stb), .byte_val(byte_val), .byte_idx(byte_idx),
      .wip(wip), .cp_mode(cp_mode), .rb_on(rb_on), .so(so), .so_en(so_en)
   );
endmodule

// File: tb/cpm_sequencer_test.sv
module cpm_sequencer_test;
   localparam int CLK_P    = 10;
   localparam int HALF     = 6;
   localparam int BUSY_LEN = 1500;
   localparam int AW       = 24;

   // vector: {short_frame, addr, data, expected request address}
   localparam int NV = 4;
   localparam logic [56:0] VEC [NV] = '{
      {1'b0, 24'hFFFFFE, 8'hA5, 24'hFFFFFE},
      {1'b1, 24'h000000, 8'h3C, 24'hFFFFFF},
      {1'b1, 24'h000000, 8'h5A, 24'h000000},
      {1'b1, 24'h000000, 8'h81, 24'h000001}
   };

   logic clk = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   logic          rst_n, cs_n, sclk, si, so, so_en, prog_req, prog_busy;
   logic [AW-1:0] prog_addr;
   logic [7:0]    prog_data;

   int            checks = 0, errors = 0, req_cnt = 0, busy_cnt = 0;
   logic [AW-1:0] cap_addr = '0;
   logic [7:0]    cap_data = '0;

   cpm_sequencer #(.ADDR_W(AW), .SYNC_STAGES(2), .RB_SUPPORT(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .si(si),
      .so(so), .so_en(so_en), .prog_req(prog_req), .prog_addr(prog_addr),
      .prog_data(prog_data), .prog_busy(prog_busy)
   );

   // behavioural program engine
   assign prog_busy = (busy_cnt != 0);
   always @(posedge clk) begin
      if (!rst_n) busy_cnt <= 0;
      else if (prog_req) begin
         busy_cnt <= BUSY_LEN;
         req_cnt  <= req_cnt + 1;
         cap_addr <= prog_addr;
         cap_data <= prog_data;
      end else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      si = b; tick(HALF); sclk = 1'b1; tick(HALF); sclk = 1'b0; tick(HALF);
   endtask

   task automatic send_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
   endtask

   task automatic cs_lo();
      cs_n = 1'b0; tick(HALF);
   endtask

   task automatic cs_hi();
      cs_n = 1'b1; tick(10);
   endtask

   task automatic frame1(input logic [7:0] op);
      cs_lo(); send_byte(op); cs_hi();
   endtask

   task automatic frame_long(input logic [AW-1:0] a, input logic [7:0] d);
      cs_lo(); send_byte(8'hAD);
      send_byte(a[23:16]); send_byte(a[15:8]); send_byte(a[7:0]);
      send_byte(d); cs_hi();
   endtask

   task automatic frame_short(input logic [7:0] d);
      cs_lo(); send_byte(8'hAD); send_byte(d); cs_hi();
   endtask

   task automatic read_reg(input logic [7:0] op, output logic [7:0] v, output logic en_ok);
      en_ok = 1'b1;
      cs_lo(); send_byte(op);
      for (int i = 7; i >= 0; i--) begin
         v[i] = so;
         if (so_en !== 1'b1) en_ok = 1'b0;
         sclk = 1'b1; tick(HALF); sclk = 1'b0; tick(HALF);
      end
      cs_hi();
   endtask

   task automatic wait_idle();
      while (prog_busy) @(negedge clk);
      tick(6);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R1: actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] v;
      logic       en;
      int         base;
      rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; si = 1'b0;
      tick(5);
      rst_n = 1'b1;
      tick(5);

      // reset state
      check("R11 reset so_en", {31'd0, so_en}, 0);
      check("R2 reset no request", req_cnt, 0);
      read_reg(8'h05, v, en);
      check("R7 status after reset", {v, 7'd0, en}, {8'h00, 7'd0, 1'b1});
      read_reg(8'h2B, v, en);
      check("R8 mode byte after reset", {24'd0, v}, 32'h00);

      // R1: frame with trailing partial byte has no effect
      cs_lo(); send_byte(8'hAD); send_byte(8'h12); send_byte(8'h34);
      send_byte(8'h56); send_byte(8'h77);
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      cs_hi();
      check("R1 partial frame no request", req_cnt, 0);
      read_reg(8'h2B, v, en);
      check("R1 partial frame mode unchanged", {24'd0, v}, 32'h00);

      // vector table: entry, continuation and address wrap
      for (int i = 0; i < NV; i++) begin
         logic [56:0] e;
         e = VEC[i];
         base = req_cnt;
         if (e[56]) frame_short(e[31:24]);
         else       frame_long(e[55:32], e[31:24]);
         check("R2 R3 request issued", req_cnt - base, 1);
         check("R3 request address", {8'd0, cap_addr}, {8'd0, e[23:0]});
         check("R2 request data", {24'd0, cap_data}, {24'd0, e[31:24]});
         wait_idle();
      end
      read_reg(8'h2B, v, en);
      check("R8 mode flag set", {24'd0, v}, 32'h10);

      // busy window: frames ignored, WIP visible, exit refused
      frame_short(8'hC1);
      check("R3 request at 000002", {8'd0, cap_addr}, 32'h000002);
      base = req_cnt;
      frame_short(8'hEE);
      check("R4 frame while busy ignored", req_cnt - base, 0);
      read_reg(8'h05, v, en);
      check("R7 WIP set while busy", {24'd0, v}, 32'h01);
      frame1(8'h04);
      read_reg(8'h2B, v, en);
      check("R6 exit refused while busy", {24'd0, v}, 32'h10);
      wait_idle();
      read_reg(8'h05, v, en);
      check("R7 WIP clear when idle", {24'd0, v}, 32'h00);
      frame_short(8'hC2);
      check("R4 address not advanced by ignored frame", {8'd0, cap_addr}, 32'h000003);
      check("R4 data of next frame", {24'd0, cap_data}, 32'hC2);
      wait_idle();

      // R5: enable opcode ignored inside mode
      frame1(8'h70);
      cs_lo(); tick(2);
      check("R5 ready/busy enable ignored in mode", {31'd0, so_en}, 0);
      cs_hi();

      frame1(8'h04);
      read_reg(8'h2B, v, en);
      check("R6 exit when idle", {24'd0, v}, 32'h00);

      // ready/busy output
      frame1(8'h70);
      cs_lo(); tick(2);
      check("R10 no drive outside mode", {31'd0, so_en}, 0);
      cs_hi();
      frame_long(24'h000010, 8'h11);
      check("R2 second entry address", {8'd0, cap_addr}, 32'h000010);
      cs_lo(); tick(2);
      check("R10 busy level", {30'd0, so_en, so}, {30'd0, 1'b1, 1'b0});
      cs_n = 1'b1; tick(2);
      check("R11 released when deselected", {31'd0, so_en}, 0);
      tick(8);
      wait_idle();
      cs_lo(); tick(2);
      check("R10 ready level", {30'd0, so_en, so}, {30'd0, 1'b1, 1'b1});
      cs_hi();
      frame1(8'h80);
      cs_lo(); tick(2);
      check("R9 disable ignored in mode", {31'd0, so_en}, 1);
      cs_hi();
      frame1(8'h04);
      frame1(8'h80);

      // R12: normal status reads inside mode with ready/busy disabled
      frame_long(24'h000020, 8'h22);
      wait_idle();
      read_reg(8'h05, v, en);
      check("R12 status byte in mode", {v, 7'd0, en}, {8'h00, 7'd0, 1'b1});
      read_reg(8'h2B, v, en);
      check("R12 mode byte in mode", {24'd0, v}, 32'h10);
      frame1(8'h04);
      read_reg(8'h2B, v, en);
      check("R6 final exit", {24'd0, v}, 32'h00);

      summary();
      $finish;
   end
endmodule